// File: doc/BRIEF.md
# Privileged System Register Access Unit

This block holds a processor's privileged machine-state registers: three control registers (numbers 0, 2 and 3) and six debug storage words (four breakpoint address registers, one debug status register and one debug control register). The execution pipeline presents one move-to or move-from request per cycle. Each request carries a direction, a control/debug select, a 3-bit register number, a 32-bit write value and the 2-bit current privilege level.

The unit decides whether the access is legal. A legal read returns the register contents. A legal write commits on the clock edge that samples the request, with the reserved fields of the debug status and debug control words forced to fixed values. An illegal access leaves every register untouched and returns a fault code. The fault checks run in a fixed order:

1. privilege level;
2. the existence of the control register number, or the debug-access lock;
3. the control register 0 value.

The result appears one cycle after the request. A two-flop synchronizer releases the asynchronous reset in step with the clock.

Top module: `sra_top`

## Requirements
- R1: A request with `req_cpl` not equal to 0 returns fault code 1 (general protection) and changes no register. This holds for reads and writes, for any register number, and whatever the state of the lock bit.
- R2: With `req_debug`=0, register numbers 1, 4, 5, 6 and 7 return fault code 2 (undefined opcode) and write nothing. Numbers 0, 2 and 3 are separate 32-bit registers that read back the last value written.
- R3: With `req_debug`=1, numbers 0 to 3 are four separate 32-bit registers. Number 6 addresses the same storage as number 4, and number 7 the same as number 5, so a write through either number is visible through the other.
- R4: While bit 13 of the debug control register (debug number 5/7) is 1, every debug read or write at privilege 0 returns fault code 1 and writes nothing. Control register accesses are not affected.
- R5: A write to control register 0 with bit 31 set and bit 0 clear returns fault code 1 and leaves the register unchanged. With both bits set, the write is accepted.
- R6: A write to control register 0 with bit 29 set and bit 30 clear returns fault code 1 and leaves the register unchanged. With both bits set, the write is accepted.
- R7: A write to the debug status register (number 4 or 6) stores the write value OR 0xFFFF1FF0.
- R8: A write to the debug control register (number 5 or 7) stores the write value AND NOT 0x0000DC00.
- R9: The privilege check takes precedence. A control register access to a missing number at a nonzero privilege level returns fault code 1, not 2.
- R10: `rsp_valid` is 1 in exactly the cycle after a cycle with `req_valid`=1. `rsp_fault` is 0 for no fault, 1 for general protection and 2 for undefined opcode. `rsp_rdata` carries the register value for a fault-free read and 0 otherwise.
- R11: After reset, every register reads 0, except the debug status register, which reads 0xFFFF1FF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move to register, 0 = move from register |
| req_debug | input | 1 | 1 = debug register space, 0 = control register space |
| req_num | input | 3 | Register number |
| req_cpl | input | 2 | Current privilege level |
| req_wdata | input | 32 | Value to write |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 2 | 0 none, 1 general protection, 2 undefined opcode |
| rsp_rdata | output | 32 | Read data, 0 on fault or write |

## Verification
Several behaviours are checked on every cycle by the assertions:

- the reserved-one and reserved-zero fields of the two debug words;
- the privilege, missing-number, lock and control register 0 faults, and the absence of any register change after them;
- the one-cycle response timing.

The remaining behaviours can only be shown by the bench's scenarios, because they need a write followed by a read:

- aliasing between debug numbers 6/7 and 4/5;
- read-back of legal values;
- the reset contents;
- the accepted control register 0 combinations;
- the fact that the lock blocks debug access but not control register access.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int XLEN = 32;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_UD   = 2'd2
  } fault_e;

  // physical storage slots
  localparam int NUM_SLOTS  = 9;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int SLOT_CR0   = 0;
  localparam int SLOT_CR2   = 1;
  localparam int SLOT_CR3   = 2;
  localparam int SLOT_DR0   = 3;
  localparam int SLOT_DSTAT = 7;
  localparam int SLOT_DCTL  = 8;

  localparam logic [XLEN-1:0] DSTAT_ONES  = 32'hFFFF_1FF0;
  localparam logic [XLEN-1:0] DCTL_ZEROS  = 32'h0000_DC00;

  localparam int CR0_PE_BIT  = 0;
  localparam int CR0_NW_BIT  = 29;
  localparam int CR0_CD_BIT  = 30;
  localparam int CR0_PG_BIT  = 31;
  localparam int DCTL_GD_BIT = 13;
endpackage

// File: rtl/sra_rst_sync.sv
module sra_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sra_decode.sv
module sra_decode
  import sra_pkg::*;
#(
  parameter int NUM_W = 3,
  parameter int CPL_W = 2
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_debug,
  input  logic [NUM_W-1:0]  req_num,
  input  logic [CPL_W-1:0]  req_cpl,
  input  logic [XLEN-1:0]   req_wdata,
  input  logic              gd_lock,
  output fault_e            fault,
  output logic [SLOT_W-1:0] slot,
  output logic              wr_en
);
  logic cr_missing;
  logic cr0_bad;

  always_comb begin
    slot       = '0;
    cr_missing = 1'b0;
    if (req_debug) begin
      case (req_num)
        3'd4, 3'd6: slot = SLOT_W'(SLOT_DSTAT);
        3'd5, 3'd7: slot = SLOT_W'(SLOT_DCTL);
        default:    slot = SLOT_W'(SLOT_DR0) + SLOT_W'(req_num[1:0]);
      endcase
    end else begin
      case (req_num)
        3'd0:    slot = SLOT_W'(SLOT_CR0);
        3'd2:    slot = SLOT_W'(SLOT_CR2);
        3'd3:    slot = SLOT_W'(SLOT_CR3);
        default: cr_missing = 1'b1;
      endcase
    end
  end

  always_comb begin
    cr0_bad = (req_wdata[CR0_PG_BIT] && !req_wdata[CR0_PE_BIT]) ||
              (req_wdata[CR0_NW_BIT] && !req_wdata[CR0_CD_BIT]);
    if (req_cpl != '0)                                    fault = FLT_GP;
    else if (!req_debug && cr_missing)                    fault = FLT_UD;
    else if (req_debug && gd_lock)                        fault = FLT_GP;
    else if (req_write && !req_debug && req_num == '0 && cr0_bad) fault = FLT_GP;
    else                                                  fault = FLT_NONE;
    wr_en = req_valid && req_write && (fault == FLT_NONE);
  end
endmodule

// File: rtl/sra_regfile.sv
module sra_regfile
  import sra_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SLOT_W-1:0]         wr_slot,
  input  logic [XLEN-1:0]           wr_data,
  output logic [NUM_SLOTS*XLEN-1:0] regs_flat
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam logic [XLEN-1:0] RST_VAL  = (i == SLOT_DSTAT) ? DSTAT_ONES : '0;
    localparam logic [XLEN-1:0] OR_MASK  = (i == SLOT_DSTAT) ? DSTAT_ONES : '0;
    localparam logic [XLEN-1:0] AND_MASK = (i == SLOT_DCTL)  ? ~DCTL_ZEROS : '1;
    logic [XLEN-1:0] q;
    logic [XLEN-1:0] d;
    logic            en;

    always_comb begin
      en = wr_en && (wr_slot == SLOT_W'(i));
      d  = en ? ((wr_data | OR_MASK) & AND_MASK) : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
    end

    assign regs_flat[i*XLEN +: XLEN] = q;

    if (i == SLOT_DSTAT) begin : g_stat_chk
      assert_status_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q & DSTAT_ONES) == DSTAT_ONES);
    end
    if (i == SLOT_DCTL) begin : g_ctl_chk
      assert_ctl_zeros_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q & DCTL_ZEROS) == '0);
    end
  end
endmodule

// File: rtl/sra_top.sv
module sra_top
  import sra_pkg::*;
#(
  parameter int NUM_W = 3,
  parameter int CPL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_debug,
  input  logic [NUM_W-1:0] req_num,
  input  logic [CPL_W-1:0] req_cpl,
  input  logic [XLEN-1:0]  req_wdata,
  output logic             rsp_valid,
  output logic [1:0]       rsp_fault,
  output logic [XLEN-1:0]  rsp_rdata
);
  logic                      rst_sync_n;
  logic [NUM_SLOTS*XLEN-1:0] regs_flat;
  fault_e                    fault;
  logic [SLOT_W-1:0]         slot;
  logic                      wr_en;
  logic                      gd_lock;
  logic [XLEN-1:0]           rd_word;

  logic            valid_d, valid_q;
  logic [1:0]      fault_d, fault_q;
  logic [XLEN-1:0] rdata_d, rdata_q;

  sra_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign gd_lock = regs_flat[SLOT_DCTL*XLEN + DCTL_GD_BIT];

  sra_decode #(.NUM_W(NUM_W), .CPL_W(CPL_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_debug(req_debug),
    .req_num(req_num), .req_cpl(req_cpl), .req_wdata(req_wdata),
    .gd_lock(gd_lock), .fault(fault), .slot(slot), .wr_en(wr_en)
  );

  sra_regfile u_rf (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_slot(slot),
    .wr_data(req_wdata), .regs_flat(regs_flat)
  );

  assign rd_word = regs_flat[slot*XLEN +: XLEN];

  always_comb begin
    valid_d = req_valid;
    fault_d = req_valid ? fault : FLT_NONE;
    rdata_d = (req_valid && !req_write && fault == FLT_NONE) ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      fault_q <= FLT_NONE;
      rdata_q <= '0;
    end else begin
      valid_q <= valid_d;
      fault_q <= fault_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_fault = fault_q;
  assign rsp_rdata = rdata_q;

  assert_cpl_gp_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid && req_cpl != '0 |=> rsp_fault == FLT_GP && $stable(regs_flat));

  assert_missing_cr_ud_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid && req_cpl == '0 && !req_debug && (req_num == 3'd1 || req_num[2])
    |=> rsp_fault == FLT_UD && $stable(regs_flat));

  assert_gd_lock_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid && req_debug && gd_lock |=> rsp_fault == FLT_GP && $stable(regs_flat));

  assert_cr0_pg_pe_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid && req_write && !req_debug && req_num == '0 &&
    req_wdata[CR0_PG_BIT] && !req_wdata[CR0_PE_BIT]
    |=> rsp_fault == FLT_GP && $stable(regs_flat));

  assert_cr0_nw_cd_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid && req_write && !req_debug && req_num == '0 &&
    req_wdata[CR0_NW_BIT] && !req_wdata[CR0_CD_BIT]
    |=> rsp_fault == FLT_GP && $stable(regs_flat));

  assert_rsp_timing_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);

  assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid);
endmodule

// File: tb/sim_sra_top.sv
`timescale 1ns/1ps
module sim_sra_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_debug;
  logic [2:0]  req_num;
  logic [1:0]  req_cpl;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [1:0]  rsp_fault;
  logic [31:0] rsp_rdata;

  always #5 clk = ~clk;

  sra_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_debug(req_debug), .req_num(req_num), .req_cpl(req_cpl),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_rdata(rsp_rdata)
  );

  int checks = 0;
  int fails  = 0;
  logic [1:0]  q_fault[$];
  logic [31:0] q_data[$];
  string       q_tag[$];

  // bench model of the requirements
  logic [31:0] m_cr0, m_cr2, m_cr3;
  logic [31:0] m_dr[6];

  task automatic access(input bit wr, input bit dbg, input logic [2:0] num,
                        input logic [31:0] d, input logic [1:0] cpl, input string tag);
    logic [1:0]  ef;
    logic [31:0] ed;
    int          idx;
    ef = 2'd0; ed = 32'h0;
    idx = (num >= 3'd6) ? int'(num) - 2 : int'(num);
    if (cpl != 2'd0) ef = 2'd1;
    else if (!dbg && (num == 3'd1 || num >= 3'd4)) ef = 2'd2;
    else if (dbg && m_dr[5][13]) ef = 2'd1;
    else if (wr && !dbg && num == 3'd0 &&
             ((d[31] && !d[0]) || (d[29] && !d[30]))) ef = 2'd1;
    if (ef == 2'd0) begin
      if (wr) begin
        if (!dbg) begin
          if (num == 3'd0) m_cr0 = d;
          else if (num == 3'd2) m_cr2 = d;
          else m_cr3 = d;
        end else if (idx == 4) m_dr[4] = d | 32'hFFFF1FF0;
        else if (idx == 5) m_dr[5] = d & ~32'h0000DC00;
        else m_dr[idx] = d;
      end else begin
        if (!dbg) ed = (num == 3'd0) ? m_cr0 : (num == 3'd2) ? m_cr2 : m_cr3;
        else ed = m_dr[idx];
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_debug = dbg;
    req_num = num; req_wdata = d; req_cpl = cpl;
    q_fault.push_back(ef); q_data.push_back(ed); q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n && rsp_valid) begin
        checks++;
        if (q_fault.size() == 0) begin
          fails++;
          $display("FAIL R10: unexpected response fault=%0d data=%h, expected none", rsp_fault, rsp_rdata);
        end else begin
          logic [1:0]  ef;
          logic [31:0] ed;
          string       t;
          ef = q_fault.pop_front(); ed = q_data.pop_front(); t = q_tag.pop_front();
          if (rsp_fault !== ef || rsp_rdata !== ed) begin
            fails++;
            $display("FAIL %s: fault=%0d data=%h, expected fault=%0d data=%h",
                     t, rsp_fault, rsp_rdata, ef, ed);
          end
        end
      end
    end
  end

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    m_cr0 = 0; m_cr2 = 0; m_cr3 = 0;
    for (int i = 0; i < 6; i++) m_dr[i] = 32'h0;
    m_dr[4] = 32'hFFFF1FF0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_debug = 1'b0;
    req_num = 3'd0; req_cpl = 2'd0; req_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset contents
    access(0, 0, 3'd0, 0, 0, "R11 cr0");
    access(0, 0, 3'd2, 0, 0, "R11 cr2");
    access(0, 0, 3'd3, 0, 0, "R11 cr3");
    access(0, 1, 3'd0, 0, 0, "R11 dr0");
    access(0, 1, 3'd4, 0, 0, "R11 dstat");
    access(0, 1, 3'd7, 0, 0, "R11 dctl");
    idle();
    // R2 implemented control registers
    access(1, 0, 3'd2, 32'h1234_5678, 0, "R2 wr cr2");
    access(1, 0, 3'd3, 32'hCAFE_F00D, 0, "R2 wr cr3");
    access(0, 0, 3'd2, 0, 0, "R2 rd cr2");
    access(0, 0, 3'd3, 0, 0, "R2 rd cr3");
    // R2 missing numbers
    access(0, 0, 3'd1, 0, 0, "R2 rd cr1");
    access(1, 0, 3'd4, 32'hFFFF_FFFF, 0, "R2 wr cr4");
    access(0, 0, 3'd7, 0, 0, "R2 rd cr7");
    access(1, 0, 3'd5, 32'h5555_5555, 0, "R2 wr cr5");
    access(0, 0, 3'd3, 0, 0, "R2 cr3 after ud");
    idle();
    // R1 privilege
    access(0, 0, 3'd0, 0, 3, "R1 rd cr0 cpl3");
    access(1, 0, 3'd3, 32'hDEAD_BEEF, 1, "R1 wr cr3 cpl1");
    access(0, 0, 3'd3, 0, 0, "R1 cr3 unchanged");
    access(1, 1, 3'd1, 32'h1111_1111, 2, "R1 wr dr1 cpl2");
    access(0, 1, 3'd1, 0, 0, "R1 dr1 unchanged");
    // R9 priority
    access(0, 0, 3'd5, 0, 2, "R9 cr5 cpl2");
    access(1, 0, 3'd1, 32'h1, 3, "R9 cr1 cpl3");
    // R5 / R6 CR0 value checks
    access(1, 0, 3'd0, 32'h8000_0000, 0, "R5 pg no pe");
    access(0, 0, 3'd0, 0, 0, "R5 cr0 unchanged");
    access(1, 0, 3'd0, 32'h8000_0001, 0, "R5 pg pe");
    access(0, 0, 3'd0, 0, 0, "R5 cr0 readback");
    access(1, 0, 3'd0, 32'h2000_0000, 0, "R6 nw no cd");
    access(0, 0, 3'd0, 0, 0, "R6 cr0 unchanged");
    access(1, 0, 3'd0, 32'h6000_0011, 0, "R6 nw cd");
    access(0, 0, 3'd0, 0, 0, "R6 cr0 readback");
    idle();
    // R3 breakpoint registers and aliases
    for (int i = 0; i < 4; i++)
      access(1, 1, 3'(i), 32'hA000_0000 + 32'(i * 17), 0, "R3 wr dr");
    for (int i = 3; i >= 0; i--)
      access(0, 1, 3'(i), 0, 0, "R3 rd dr");
    access(1, 1, 3'd6, 32'h0, 0, "R7 wr dr6 zero");
    access(0, 1, 3'd4, 0, 0, "R7 rd dr4 alias");
    access(1, 1, 3'd4, 32'h0000_000F, 0, "R3 wr dr4");
    access(0, 1, 3'd6, 0, 0, "R3 rd dr6 alias");
    access(1, 1, 3'd7, 32'hFFFF_DFFF, 0, "R8 wr dr7 ones");
    access(0, 1, 3'd5, 0, 0, "R8 rd dr5 alias");
    access(1, 1, 3'd5, 32'h0000_0055, 0, "R3 wr dr5");
    access(0, 1, 3'd7, 0, 0, "R3 rd dr7 alias");
    idle();
    // R4 global lock
    access(1, 1, 3'd7, 32'h0000_2003, 0, "R4 set lock");
    access(0, 1, 3'd0, 0, 0, "R4 rd dr0 locked");
    access(1, 1, 3'd1, 32'h7777_7777, 0, "R4 wr dr1 locked");
    access(0, 1, 3'd5, 0, 0, "R4 rd dr5 locked");
    access(1, 1, 3'd7, 32'h0, 0, "R4 clear attempt");
    access(0, 1, 3'd2, 0, 3, "R1 locked cpl3");
    access(0, 0, 3'd2, 0, 0, "R4 cr2 unaffected");
    access(1, 0, 3'd3, 32'h0BAD_CAFE, 0, "R4 wr cr3 unaffected");
    access(0, 0, 3'd3, 0, 0, "R4 rd cr3 unaffected");
    idle();
    repeat (4) @(negedge clk);

    checks++;
    if (q_fault.size() != 0) begin
      fails++;
      $display("FAIL R10: %0d responses missing, expected 0", q_fault.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule